// File: doc/BRIEF.md
# I2C Bus Condition Detector

This block watches the two lines of an I2C bus, already synchronised to the system clock, and reports the framing conditions on them. It pulses an output for each Start, Repeated Start and Stop. It keeps a bus-busy status. It also flags a collision when the local transmitter asks to pull SDA low for a Start while SDA is already low.

Edges are found by comparing the current sample of each line with the sample held from the previous clock. A Start or Stop needs SCL high in both samples, so a sample in which SDA and SCL change together produces no condition. A small state machine tracks whether SCL has gone low since the last Start. A Stop, or a Repeated Start, is honoured only after such a low period. It has three states:
- `ST_IDLE`: the bus is free.
- `ST_HELD`: a Start has been seen and SCL has not yet gone low.
- `ST_ARMED`: SCL has been low since the last Start.

Its transitions are:
- START: `ST_IDLE` to `ST_HELD` on an SDA fall.
- SCL_LOW: `ST_HELD` to `ST_ARMED` on an SCL low sample.
- RESTART: `ST_ARMED` to `ST_HELD` on an SDA fall.
- STOP: `ST_ARMED` to `ST_IDLE` on an SDA rise.

Any other event leaves the state as it is.

An interrupt request combines the event pulses with two enable bits and a mode flag. The mode flag marks an operating mode in which Start and Stop interrupts are always on.

Top module: `i2c_cond_det`

## Requirements
- R1: While reset is low and in the first cycle after it, every output (`start_p`, `rstart_p`, `stop_p`, `bus_busy`, `start_coll`, `irq`) is 0.
- R2: From idle, a sample with SDA going from 1 to 0 while SCL is 1 in both the previous and the current sample gives one cycle of `start_p` in the next cycle and sets `bus_busy`.
- R3: After a Start, an SDA rise while SCL stays high, before any SCL low sample, gives no pulse and `bus_busy` stays 1. An SDA fall in that same period is also ignored.
- R4: Once SCL has been sampled low since the last Start or Repeated Start, an SDA rise with SCL high in both samples gives one cycle of `stop_p` and clears `bus_busy`.
- R5: In that same armed condition, an SDA fall with SCL high in both samples gives one cycle of `rstart_p`, and not of `start_p`. `bus_busy` stays 1, and a fresh SCL low is then needed before a Stop.
- R6: A sample in which SDA and SCL both change gives no Start, Repeated Start or Stop.
- R7: A rise of `sda_drive_lo` while the bus is idle and `sda_in` is 0 sets `start_coll` in the next cycle. The flag stays set until a cycle with `coll_clr` high and no new set; a set in the same cycle as a clear wins.
- R8: A rise of `sda_drive_lo` while `sda_in` is 1, or while the bus is busy, leaves `start_coll` unchanged.
- R9: `irq` is high in exactly the cycles where either of two things holds. The first is `start_p` or `rstart_p` high with `start_ie` or `mode_irq_on` high. The second is `stop_p` high with `stop_ie` or `mode_irq_on` high.
- R10: At most one of `start_p`, `rstart_p` and `stop_p` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sda_in | input | 1 | Synchronised SDA level |
| scl_in | input | 1 | Synchronised SCL level |
| sda_drive_lo | input | 1 | Local request to pull SDA low |
| start_ie | input | 1 | Enables interrupts on Start and Repeated Start |
| stop_ie | input | 1 | Enables interrupts on Stop |
| mode_irq_on | input | 1 | Mode in which Start and Stop interrupts are always on |
| coll_clr | input | 1 | Clears the Start collision flag |
| start_p | output | 1 | One-cycle Start pulse |
| rstart_p | output | 1 | One-cycle Repeated Start pulse |
| stop_p | output | 1 | One-cycle Stop pulse |
| bus_busy | output | 1 | Bus is active |
| start_coll | output | 1 | Sticky Start collision flag |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle. The first is setting the collision flag by a fresh drive request on a low SDA while the bus is idle. The second is clearing that flag by `coll_clr`. The bench provokes this on purpose with a directed step that raises both together, and it also meets the case often under random stimulus. The result is judged against a bench model in which the set wins. A second overlap arises when an event pulse coincides with a change of the enables. It is judged by recomputing `irq` from the enables present in the pulse cycle.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HELD  = 2'd1,
        ST_ARMED = 2'd2
    } bus_state_e;

    typedef struct packed {
        logic sda_fall;
        logic sda_rise;
        logic scl_low;
    } line_events_t;

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler
    import i2c_cond_pkg::*;
#(
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sda_in,
    input  logic         scl_in,
    output line_events_t ev
);

    logic sda_q;
    logic scl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_q <= IDLE_LEVEL;
            scl_q <= IDLE_LEVEL;
        end else begin
            sda_q <= sda_in;
            scl_q <= scl_in;
        end
    end

    // SCL must be high in both samples: a joint change gives no condition
    always_comb begin
        ev.sda_fall = sda_q & ~sda_in & scl_q & scl_in;
        ev.sda_rise = ~sda_q & sda_in & scl_q & scl_in;
        ev.scl_low  = ~scl_in;
    end

endmodule

// File: rtl/i2c_cond_fsm.sv
module i2c_cond_fsm
    import i2c_cond_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  line_events_t ev,
    output logic         start_p,
    output logic         rstart_p,
    output logic         stop_p,
    output logic         bus_busy
);

    bus_state_e state_q;
    bus_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (ev.sda_fall) state_d = ST_HELD;
            ST_HELD:  if (ev.scl_low)  state_d = ST_ARMED;
            ST_ARMED: begin
                if (ev.sda_fall)      state_d = ST_HELD;
                else if (ev.sda_rise) state_d = ST_IDLE;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_p  <= 1'b0;
            rstart_p <= 1'b0;
            stop_p   <= 1'b0;
            bus_busy <= 1'b0;
        end else begin
            start_p  <= (state_q == ST_IDLE)  && ev.sda_fall;
            rstart_p <= (state_q == ST_ARMED) && ev.sda_fall;
            stop_p   <= (state_q == ST_ARMED) && ev.sda_rise;
            bus_busy <= (state_d != ST_IDLE);
        end
    end

endmodule

// File: rtl/i2c_start_coll.sv
module i2c_start_coll (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_in,
    input  logic sda_drive_lo,
    input  logic bus_idle,
    input  logic coll_clr,
    output logic start_coll
);

    logic drv_q;
    logic set_now;

    assign set_now = sda_drive_lo & ~drv_q & bus_idle & ~sda_in;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_q      <= 1'b0;
            start_coll <= 1'b0;
        end else begin
            drv_q <= sda_drive_lo;
            if (set_now)       start_coll <= 1'b1;
            else if (coll_clr) start_coll <= 1'b0;
        end
    end

endmodule

// File: rtl/i2c_irq_gate.sv
module i2c_irq_gate (
    input  logic start_p,
    input  logic rstart_p,
    input  logic stop_p,
    input  logic start_ie,
    input  logic stop_ie,
    input  logic mode_irq_on,
    output logic irq
);

    logic start_en;
    logic stop_en;

    always_comb begin
        start_en = start_ie | mode_irq_on;
        stop_en  = stop_ie | mode_irq_on;
        irq      = ((start_p | rstart_p) & start_en) | (stop_p & stop_en);
    end

endmodule

// File: rtl/i2c_cond_det.sv
module i2c_cond_det
    import i2c_cond_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sda_in,
    input  logic scl_in,
    input  logic sda_drive_lo,
    input  logic start_ie,
    input  logic stop_ie,
    input  logic mode_irq_on,
    input  logic coll_clr,
    output logic start_p,
    output logic rstart_p,
    output logic stop_p,
    output logic bus_busy,
    output logic start_coll,
    output logic irq
);

    line_events_t ev;

    i2c_line_sampler #(.IDLE_LEVEL(1'b1)) u_sampler (
        .clk    (clk),
        .rst_n  (rst_n),
        .sda_in (sda_in),
        .scl_in (scl_in),
        .ev     (ev)
    );

    i2c_cond_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .start_p  (start_p),
        .rstart_p (rstart_p),
        .stop_p   (stop_p),
        .bus_busy (bus_busy)
    );

    i2c_start_coll u_coll (
        .clk          (clk),
        .rst_n        (rst_n),
        .sda_in       (sda_in),
        .sda_drive_lo (sda_drive_lo),
        .bus_idle     (~bus_busy),
        .coll_clr     (coll_clr),
        .start_coll   (start_coll)
    );

    i2c_irq_gate u_irq (
        .start_p     (start_p),
        .rstart_p    (rstart_p),
        .stop_p      (stop_p),
        .start_ie    (start_ie),
        .stop_ie     (stop_ie),
        .mode_irq_on (mode_irq_on),
        .irq         (irq)
    );

endmodule

// File: rtl/i2c_cond_det_chk.sv
module i2c_cond_det_chk (
    input logic clk,
    input logic rst_n,
    input logic sda_in,
    input logic scl_in,
    input logic coll_clr,
    input logic start_p,
    input logic rstart_p,
    input logic stop_p,
    input logic bus_busy,
    input logic start_coll,
    input logic irq
);

    AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_p, rstart_p, stop_p})); // R10

    AST_START_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |-> (!$past(sda_in) && $past(scl_in) && bus_busy)); // R2

    AST_STOP_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |-> ($past(sda_in) && $past(scl_in) && !bus_busy)); // R4

    AST_RSTART_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rstart_p |-> ($past(bus_busy) && bus_busy)); // R5

    AST_BUSY_FALL_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_busy) |-> stop_p); // R4

    AST_COLL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start_coll) && !$past(coll_clr)) |-> start_coll); // R7

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (start_p || rstart_p || stop_p)); // R9

endmodule

bind i2c_cond_det i2c_cond_det_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_in     (sda_in),
    .scl_in     (scl_in),
    .coll_clr   (coll_clr),
    .start_p    (start_p),
    .rstart_p   (rstart_p),
    .stop_p     (stop_p),
    .bus_busy   (bus_busy),
    .start_coll (start_coll),
    .irq        (irq)
);

// File: tb/i2c_cond_det_test.sv
module i2c_cond_det_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sda_in = 1'b1, scl_in = 1'b1, sda_drive_lo = 1'b0;
    logic start_ie = 1'b0, stop_ie = 1'b0, mode_irq_on = 1'b0, coll_clr = 1'b0;
    logic start_p, rstart_p, stop_p, bus_busy, start_coll, irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // bench model state: 0 idle, 1 started without SCL low, 2 armed
    logic m_psda = 1'b1, m_pscl = 1'b1, m_pdrv = 1'b0;
    int   m_st = 0;
    logic e_start = 0, e_rstart = 0, e_stop = 0, e_busy = 0, e_coll = 0;

    always #4 clk = ~clk;

    i2c_cond_det uut (
        .clk(clk), .rst_n(rst_n), .sda_in(sda_in), .scl_in(scl_in),
        .sda_drive_lo(sda_drive_lo), .start_ie(start_ie), .stop_ie(stop_ie),
        .mode_irq_on(mode_irq_on), .coll_clr(coll_clr),
        .start_p(start_p), .rstart_p(rstart_p), .stop_p(stop_p),
        .bus_busy(bus_busy), .start_coll(start_coll), .irq(irq)
    );

    function automatic logic exp_irq();
        return ((e_start || e_rstart) && (start_ie || mode_irq_on)) ||
               (e_stop && (stop_ie || mode_irq_on));
    endfunction

    task automatic model_tick();
        logic fall, rise, cset;
        fall = m_psda && !sda_in && m_pscl && scl_in;
        rise = !m_psda && sda_in && m_pscl && scl_in;
        cset = sda_drive_lo && !m_pdrv && (m_st == 0) && !sda_in;
        e_start = 0; e_rstart = 0; e_stop = 0;
        if (m_st == 0 && fall) begin
            e_start = 1; m_st = 1;
        end else if (m_st == 1) begin
            if (!scl_in) m_st = 2;
        end else if (m_st == 2) begin
            if (fall) begin e_rstart = 1; m_st = 1; end
            else if (rise) begin e_stop = 1; m_st = 0; end
        end
        e_busy = (m_st != 0);
        if (cset) e_coll = 1;
        else if (coll_clr) e_coll = 0;
        m_psda = sda_in; m_pscl = scl_in; m_pdrv = sda_drive_lo;
    endtask

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(start_p,    e_start,   tag, "start_p (R2)");
        chk(rstart_p,   e_rstart,  tag, "rstart_p (R5)");
        chk(stop_p,     e_stop,    tag, "stop_p (R4)");
        chk(bus_busy,   e_busy,    tag, "bus_busy (R3)");
        chk(start_coll, e_coll,    tag, "start_coll (R7)");
        chk(irq,        exp_irq(), tag, "irq (R9)");
        chk(1'($countones({start_p, rstart_p, stop_p}) <= 1), 1'b1, tag, "pulse exclusivity (R10)");
    endtask

    task automatic step(input logic s, input logic c, input logic d, input logic cl, input string tag);
        sda_in = s; scl_in = c; sda_drive_lo = d; coll_clr = cl;
        @(posedge clk);
        model_tick();
        @(negedge clk);
        compare(tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20251));
        repeat (3) @(negedge clk);
        compare("R1 in reset");
        rst_n = 1'b1;
        step(1, 1, 0, 0, "R1 after reset");

        // R2 start, then R3 rise/fall before SCL low ignored
        start_ie = 1; stop_ie = 1;
        step(0, 1, 0, 0, "R2 start");
        step(1, 1, 0, 0, "R3 early rise");
        chk(bus_busy, 1'b1, "R3", "busy held after early rise");
        step(0, 1, 0, 0, "R3 early fall");
        // SCL low, then repeated start
        step(0, 0, 0, 0, "R5 scl low");
        step(1, 0, 0, 0, "R5 sda up");
        step(1, 1, 0, 0, "R5 scl up");
        step(0, 1, 0, 0, "R5 restart");
        step(1, 1, 0, 0, "R5 no stop before fresh low");
        // proper stop
        step(1, 0, 0, 0, "R4 scl low");
        step(0, 0, 0, 0, "R4 sda low");
        step(0, 1, 0, 0, "R4 scl up");
        step(1, 1, 0, 0, "R4 stop");
        chk(bus_busy, 1'b0, "R4", "bus free after stop");

        // R6 joint change from idle: SDA and SCL fall together, then rise together
        step(0, 0, 0, 0, "R6 joint fall");
        step(1, 1, 0, 0, "R6 joint rise");
        chk(bus_busy, 1'b0, "R6", "no start on joint change");

        // R9 interrupts masked, then forced by mode
        start_ie = 0; stop_ie = 0; mode_irq_on = 0;
        step(0, 1, 0, 0, "R9 start masked");
        step(0, 0, 0, 0, "R9 low");
        step(0, 1, 0, 0, "R9 high");
        mode_irq_on = 1;
        step(1, 1, 0, 0, "R9 stop forced");
        mode_irq_on = 0;

        // R8 drive with SDA high: no collision; R7 drive with SDA low: set
        step(1, 1, 1, 0, "R8 drive sda high");
        step(1, 1, 0, 0, "R8 release");
        step(0, 0, 0, 0, "R7 sda low idle");
        step(0, 0, 1, 1, "R7 set beats clear");
        chk(start_coll, 1'b1, "R7", "set wins over clear");
        step(0, 0, 1, 0, "R7 held");
        step(0, 0, 0, 1, "R7 clear");
        chk(start_coll, 1'b0, "R7", "cleared");
        // R8 drive while busy with SDA low
        step(1, 1, 0, 0, "R8 idle");
        step(0, 1, 0, 0, "R8 start");
        step(0, 0, 1, 0, "R8 drive while busy");
        chk(start_coll, 1'b0, "R8", "no set while busy");
        step(0, 0, 0, 0, "R8 drop");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic s, c, d, cl;
            s = ($urandom % 4 == 0) ? ~sda_in : sda_in;
            c = ($urandom % 3 == 0) ? ~scl_in : scl_in;
            d = ($urandom % 6 == 0) ? ~sda_drive_lo : sda_drive_lo;
            cl = ($urandom % 8 == 0);
            if ($urandom % 50 == 0) begin
                start_ie = 1'($urandom); stop_ie = 1'($urandom); mode_irq_on = 1'($urandom);
            end
            step(s, c, d, cl, "random");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule